// File: doc/BRIEF.md
# Dual-Modulus Prescaler Divider

This block divides a fast input clock by one of four ratios: 128, 129, 64 or 65. A front stage counts input edges in groups of four, or five when a swallow is due, and each completed group advances a five-stage synchronous counter. When the extra edge is wanted, only the final counter step of a period is stretched to five input edges. When the short group is wanted, one counter stage is skipped, which halves the number of counter steps per period.

Two level inputs choose the ratio. `base_sel` picks the plain ratio or the plain ratio plus one, and `half_grp` picks the 128/129 group or the 64/65 group. `base_sel` may be moved during operation and takes effect per output period. `half_grp` is a quasi-static strap: it is changed only while reset is held, and an integrator who leaves it unused ties it low, which selects the 128/129 group. The output is a divided clock that is low for the first half of each period and high for the rest. A one-cycle strobe marks the final input cycle of each period, so a synthesizer loop or a bench can count exact period lengths.

Top module: `dmod_prescaler`

## Requirements
- R1: With `half_grp`=0 the period is 128 input cycles when `base_sel`=1 and 129 when `base_sel`=0; with `half_grp`=1 it is 64 when `base_sel`=1 and 65 when `base_sel`=0.
- R2: With both select inputs steady, consecutive periods all have the same length.
- R3: `base_sel` is sampled once per period, at the rising edge that starts the final counter step (input count 124 of 128/129, or 60 of 64/65); a change made after that edge leaves the current period unchanged and applies to the next one.
- R4: A change of `base_sel` made in the first input cycle of a period applies to that same period.
- R5: `div_out` rises when the period reaches input count 64 (128/129 group) or 32 (64/65 group), so it is low for exactly 64 or 32 input cycles of each period, counting from count 0.
- R6: `div_out` falls at the rising edge that ends the final count of a period, so it is low in the input cycle right after each strobe.
- R7: `period_strobe` is high for exactly one input cycle per period, the final one (count N-1 of an N-cycle period).
- R8: While reset is asserted `div_out` is 1 and `period_strobe` is 0; after release `div_out` stays high through the whole first period and first falls one full selected ratio of counting edges after release.
- R9: Reset is asserted asynchronously and released in step with `clk_in` after two rising edges, so the first strobe is seen N+1 input cycles after `rst_n` rises between edges, where N is the selected ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| base_sel | input | 1 | 1 selects the plain ratio (128 or 64), 0 adds one input cycle (129 or 65) |
| half_grp | input | 1 | 0 selects the 128/129 group, 1 the 64/65 group; change only under reset, tie low if unused |
| div_out | output | 1 | Divided clock: low from count 0, high from the half-period count to the end of the period |
| period_strobe | output | 1 | High during the final input cycle of every period |

## Verification
All four select combinations are run, each for more than one period, and the period length and the number of low output cycles are counted; this separates a wrong swallow count (length off by one) from a wrong skip stage (length halved or doubled) and from a misplaced rising point (low count wrong). Moving `base_sel` right after a strobe and again late in the final counter step tells apart sampling at the correct edge from sampling too early or continuously. Resets in both groups, one of them with the extra cycle already selected, show the held reset outputs, the two-edge release and the length of the first period.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

  // Default structure: a 4/5 front stage feeding a 5-stage counter,
  // with stage index 3 skipped for the short group.
  localparam int unsigned DEF_BASE_DIV   = 4;
  localparam int unsigned DEF_STAGES     = 5;
  localparam int unsigned DEF_SKIP_STAGE = 3;
  localparam int unsigned DEF_SYNC_DEPTH = 2;

  // Decoded counter state handed to the output and swallow logic.
  typedef struct packed {
    logic last;      // counter sits in its final step
    logic penult;    // counter sits in the step before the final one
    logic half_hit;  // this front tick moves the counter to its half point
    logic wrap;      // this front tick closes the period
  } cnt_stat_t;

endpackage

// File: rtl/dmod_rst_sync.sv
module dmod_rst_sync #(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [SYNC_DEPTH-1:0] sync_q;
  logic [SYNC_DEPTH-1:0] sync_d;

  // Shift ones in after the asynchronous reset has been removed.
  always_comb begin
    sync_d = {sync_q[SYNC_DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[SYNC_DEPTH-1];

endmodule

// File: rtl/dmod_front.sv
module dmod_front #(
  parameter int unsigned BASE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stretch,  // count one extra input edge in this group
  output logic tick      // high in the last input cycle of a group
);

  localparam int unsigned FS_W = $clog2(BASE_DIV + 1);

  logic [FS_W-1:0] cnt_q;
  logic [FS_W-1:0] cnt_d;
  logic [FS_W-1:0] term;

  always_comb begin
    term  = stretch ? FS_W'(BASE_DIV) : FS_W'(BASE_DIV - 1);
    tick  = (cnt_q == term);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dmod_count.sv
module dmod_count
  import dmod_pkg::*;
#(
  parameter int unsigned STAGES     = 5,
  parameter int unsigned SKIP_STAGE = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,       // front stage tick
  input  logic      half_grp,  // skip stage SKIP_STAGE
  output cnt_stat_t stat
);

  localparam logic [STAGES-1:0] LSB_ONLY = {{(STAGES-1){1'b0}}, 1'b1};
  localparam int unsigned       TOP     = STAGES - 1;

  logic [STAGES-1:0] q_q;
  logic [STAGES-1:0] q_d;
  logic [STAGES-1:0] act;
  logic [STAGES:0]   carry;

  assign carry[0] = adv;

  // Synchronous toggle chain; a skipped stage passes its carry straight
  // through and holds zero.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == SKIP_STAGE) begin : g_skip
      assign act[g] = ~half_grp;
    end else begin : g_keep
      assign act[g] = 1'b1;
    end
    assign carry[g+1] = act[g] ? (carry[g] & q_q[g]) : carry[g];
    assign q_d[g]     = act[g] & (q_q[g] ^ carry[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (adv) begin
      q_q <= q_d;
    end
  end

  always_comb begin
    stat.last     = ((q_q & act) == act);
    stat.penult   = ((q_q & act) == (act & ~LSB_ONLY));
    stat.half_hit = carry[TOP] & ~q_q[TOP];
    stat.wrap     = carry[STAGES];
  end

endmodule

// File: rtl/dmod_outgen.sv
module dmod_outgen
  import dmod_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cnt_stat_t stat,
  output logic      div_out,
  output logic      period_strobe
);

  logic out_q;
  logic out_d;

  always_comb begin
    out_d = out_q;
    if (stat.wrap) begin
      out_d = 1'b0;
    end else if (stat.half_hit) begin
      out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b1;
    end else begin
      out_q <= out_d;
    end
  end

  assign div_out       = out_q;
  assign period_strobe = stat.wrap;

endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
  import dmod_pkg::*;
#(
  parameter int unsigned BASE_DIV   = DEF_BASE_DIV,
  parameter int unsigned STAGES     = DEF_STAGES,
  parameter int unsigned SKIP_STAGE = DEF_SKIP_STAGE,
  parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic base_sel,
  input  logic half_grp,
  output logic div_out,
  output logic period_strobe
);

  logic      rst_sync_n;
  logic      fs_tick;
  logic      stretch;
  logic      load_en;
  logic      swallow_q;
  logic      swallow_d;
  cnt_stat_t stat;

  dmod_rst_sync #(
    .SYNC_DEPTH(SYNC_DEPTH)
  ) u_rst_sync (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  dmod_front #(
    .BASE_DIV(BASE_DIV)
  ) u_front (
    .clk    (clk_in),
    .rst_n  (rst_sync_n),
    .stretch(stretch),
    .tick   (fs_tick)
  );

  dmod_count #(
    .STAGES    (STAGES),
    .SKIP_STAGE(SKIP_STAGE)
  ) u_count (
    .clk     (clk_in),
    .rst_n   (rst_sync_n),
    .adv     (fs_tick),
    .half_grp(half_grp),
    .stat    (stat)
  );

  dmod_outgen u_outgen (
    .clk          (clk_in),
    .rst_n        (rst_sync_n),
    .stat         (stat),
    .div_out      (div_out),
    .period_strobe(period_strobe)
  );

  // Swallow request: captured on the edge that enters the final counter
  // step, used only during that step.
  always_comb begin
    load_en   = fs_tick & stat.penult;
    swallow_d = load_en ? ~base_sel : swallow_q;
    stretch   = swallow_q & stat.last;
  end

  always_ff @(posedge clk_in or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      swallow_q <= 1'b0;
    end else begin
      swallow_q <= swallow_d;
    end
  end

endmodule

// File: rtl/dmod_prescaler_chk.sv
module dmod_prescaler_chk #(
  parameter int unsigned FULL_RATIO = 128
) (
  input logic clk,
  input logic rst_n,
  input logic half_grp,
  input logic div_out,
  input logic period_strobe
);

  localparam logic [7:0] FULL_N = 8'(FULL_RATIO);
  localparam logic [7:0] HALF_N = 8'(FULL_RATIO / 2);

  logic [7:0] since_q;
  logic [7:0] base_n;
  logic [7:0] rise_pt;

  assign base_n  = half_grp ? HALF_N : FULL_N;
  assign rise_pt = base_n >> 1;

  // Input cycles since the period began.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
    end else if (period_strobe) begin
      since_q <= '0;
    end else if (since_q != 8'hff) begin
      since_q <= since_q + 8'd1;
    end
  end

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |=> !period_strobe);

  a_r6_low_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |=> !div_out);

  a_r6_fall_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_out) |-> $past(period_strobe));

  a_r5_rise_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_out) |-> (since_q == rise_pt));

  a_r1_period_len: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |-> ((since_q == base_n - 8'd1) || (since_q == base_n)));

endmodule

bind dmod_prescaler dmod_prescaler_chk u_chk (
  .clk          (clk_in),
  .rst_n        (rst_sync_n),
  .half_grp     (half_grp),
  .div_out      (div_out),
  .period_strobe(period_strobe)
);

// File: tb/dmod_prescaler_bench.sv
module dmod_prescaler_bench;

  logic clk      = 1'b0;
  logic rst_n    = 1'b0;
  logic base_sel = 1'b1;
  logic half_grp = 1'b0;
  logic div_out;
  logic period_strobe;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  dmod_prescaler u_dmod_prescaler (
    .clk_in       (clk),
    .rst_n        (rst_n),
    .base_sel     (base_sel),
    .half_grp     (half_grp),
    .div_out      (div_out),
    .period_strobe(period_strobe)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=%0d expected=<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R8, R9: reset state, release, length of the first period.
  task automatic do_reset(input logic grp, input logic base, input int n_exp, input string tag);
    int  k;
    bit  early_low;
    @(negedge clk);
    rst_n    = 1'b0;
    half_grp = grp;
    base_sel = base;
    repeat (3) @(negedge clk);
    chk(div_out === 1'b1, {"R8 div_out in reset ", tag}, int'(div_out), 1);
    chk(period_strobe === 1'b0, {"R8 strobe in reset ", tag}, int'(period_strobe), 0);
    rst_n     = 1'b1;
    k         = 0;
    early_low = 1'b0;
    do begin
      @(negedge clk);
      k++;
      if (div_out !== 1'b1) early_low = 1'b1;
    end while (period_strobe !== 1'b1 && k < 400);
    chk(k == n_exp + 1, {"R9 first strobe after release ", tag}, k, n_exp + 1);
    chk(!early_low, {"R8 high through first period ", tag}, int'(early_low), 0);
  endtask

  // R1, R2, R5, R6, R7: one period from just after a strobe to the next.
  task automatic measure(input int n_exp, input int low_exp, input string tag);
    int k;
    int lows;
    k    = 0;
    lows = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) chk(div_out === 1'b0, {"R6 low after strobe ", tag}, int'(div_out), 0);
      if (div_out === 1'b0) lows++;
    end while (period_strobe !== 1'b1 && k < 400);
    chk(k == n_exp, {"R1 R7 period length ", tag}, k, n_exp);
    chk(lows == low_exp, {"R5 low cycles ", tag}, lows, low_exp);
  endtask

  // R3: move base_sel inside the final counter step; current period keeps old length.
  task automatic late_change(input int steps, input int n_old, input logic new_base, input string tag);
    int k;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 4 * steps - 1) base_sel = new_base;
    end while (period_strobe !== 1'b1 && k < 400);
    chk(k == n_old, {"R3 late change ignored ", tag}, k, n_old);
  endtask

  initial begin
    // 128/129 group
    do_reset(1'b0, 1'b1, 128, "grp0 base1");
    measure(128, 64, "R1 ratio 128");
    measure(128, 64, "R2 steady 128");
    base_sel = 1'b0;
    measure(129, 64, "R4 early change to 129");
    measure(129, 64, "R2 steady 129");
    late_change(32, 129, 1'b1, "129 to 128");
    measure(128, 64, "R3 next period 128");
    late_change(32, 128, 1'b0, "128 to 129");
    measure(129, 64, "R3 next period 129");

    // 64/65 group
    do_reset(1'b1, 1'b1, 64, "grp1 base1");
    measure(64, 32, "R1 ratio 64");
    measure(64, 32, "R2 steady 64");
    base_sel = 1'b0;
    measure(65, 32, "R4 early change to 65");
    late_change(16, 65, 1'b1, "65 to 64");
    measure(64, 32, "R3 next period 64");

    // Reset with the extra cycle already selected
    do_reset(1'b0, 1'b0, 129, "grp0 base0");
    measure(129, 64, "R1 ratio 129 after reset");

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule